// File: doc/BRIEF.md
# Serial Flash Read Command Engine

This block is the slave side of the two read commands of a serial flash: a plain read and a fast read. A host selects the device by pulling chip select low. It then clocks in an 8-bit opcode and a 24-bit start address, most significant bit first, with each bit taken on a rising serial clock edge. For the fast read it also clocks in 8 dummy bits. After that the block fetches bytes from a memory array through a synchronous read port. It shifts each byte out on the serial output, one bit per falling edge. The address steps up after every byte and wraps from the top of the array to zero, so one command can stream the array forever. Raising chip select ends the command at any point. An unknown opcode, or a read issued while the internal write/erase logic reports busy, is refused, and the output stays off until chip select rises.

The serial pins are sampled by the system clock through a synchronizer, and the serial clock edges are found from the synchronized copy. The serial clock must therefore stay high for at least 6 system clock cycles and low for at least 6 system clock cycles. The output is a pad driver pair: `so_d` is the data and `so_oe` is the enable. The pad is high impedance when `so_oe` is 0.

The controller has eight states. IDLE moves to OPCODE when chip select goes low. OPCODE takes 8 bits, then goes to ADDR when the opcode is accepted, or to REJECT when it is refused. ADDR takes 24 bits, then goes to DUMMY for a fast read or to FETCH for a plain read. DUMMY takes 8 bits, then goes to FETCH. FETCH issues a memory read and goes to LOAD. LOAD captures the data and goes to STREAM. STREAM shifts out 8 bits, then steps the address and goes back to FETCH. REJECT stays where it is. From every state, chip select high leads to IDLE.

Top module: `spi_read_engine`

## Requirements
- R1: After reset, and whenever chip select is high, `so_oe` is 0 and `mem_rd_en` is 0.
- R2: Opcode 03h starts a plain read. Its first data bit is driven on the falling edge that follows the 32nd rising edge: 8 opcode bits, then 24 address bits.
- R3: Opcode 0Bh starts a fast read. The 8 bits after the address are ignored, and the first data bit follows the 40th rising edge.
- R4: Data bits are driven on falling edges, most significant bit first. Each bit is stable by the next rising edge, and `so_oe` is 1 while data is streamed.
- R5: The first byte comes from the start address. Each following byte comes from the previous address plus one.
- R6: After the byte at address MEM_DEPTH-1, the next byte comes from address 0.
- R7: The start address is formed from the lowest log2(MEM_DEPTH) bits of the 24-bit address, and the upper bits are ignored. A start address beyond the top of a depth that is not a power of two begins at 0.
- R8: `so_oe` is 0 during the opcode, address and dummy bits.
- R9: Any opcode other than 03h or 0Bh keeps `so_oe` at 0 and issues no memory read until chip select rises.
- R10: If `busy` is 1 when the 8th opcode bit is taken, the read is refused: no memory read and `so_oe` stays 0 for the whole selection, even if `busy` drops later.
- R11: Raising chip select at any bit, including inside an address or a data byte, turns `so_oe` off within 4 system cycles. The next selection decodes from a fresh opcode.
- R12: Each memory read is a one-cycle `mem_rd_en` pulse, and `mem_rdata` is taken on the following cycle. An accepted read that streams N whole bytes, and is then deselected with the serial clock low, issues N+1 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data in |
| busy | input | 1 | Write/erase cycle in progress |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial out drive enable (0 = high impedance) |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | log2(MEM_DEPTH) | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the strobe |

## Verification
The bench compares each streamed bit with a behavioural model at the point where a host would sample it. It runs plain and fast reads from a low address, reads that straddle the top of the array, and reads whose upper address bits are non-zero. These cases separate a wrong dummy length, a missing wrap and a truncated address. Refused selections use an unknown opcode, a busy flag that stays high, and a busy flag that drops right after the opcode. These show whether refusal is decided once, at the opcode, and whether it stops memory traffic. Deselection inside an address and inside a data byte, each followed by a normal read, shows that no bit counts or output drive carry over between selections.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_FETCH,
        ST_LOAD,
        ST_STREAM,
        ST_REJECT
    } rd_state_e;

    localparam logic [7:0] OPC_READ      = 8'h03;
    localparam logic [7:0] OPC_FAST_READ = 8'h0B;

    localparam int OPC_BITS   = 8;
    localparam int ADDR_BITS  = 24;
    localparam int DUMMY_BITS = 8;
    localparam int BYTE_BITS  = 8;

endpackage

// File: rtl/sre_sync_edge.sv
module sre_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic si_i,
    output logic cs_n_s,
    output logic si_s,
    output logic sck_rise,
    output logic sck_fall
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] RST_VAL = 3'b001;

    logic [STAGES-1:0][NSIG-1:0] stage_q;
    logic                        sck_prev_q;
    logic [NSIG-1:0]             synced;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q    <= {STAGES{RST_VAL}};
            sck_prev_q <= 1'b0;
        end else begin
            stage_q    <= {stage_q[STAGES-2:0], {si_i, sck_i, cs_n_i}};
            sck_prev_q <= synced[1];
        end
    end

    assign synced   = stage_q[STAGES-1];
    assign cs_n_s   = synced[0];
    assign si_s     = synced[2];
    assign sck_rise = synced[1] & ~sck_prev_q;
    assign sck_fall = ~synced[1] & sck_prev_q;

    assert_edge_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_rise && sck_fall));

endmodule

// File: rtl/sre_addr_ctr.sv
module sre_addr_ctr #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [23:0]   load_addr,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] start_addr;

    generate
        if (DEPTH == (1 << AW)) begin : g_pow2
            assign start_addr = load_addr[AW-1:0];
        end else begin : g_clamp
            assign start_addr = (load_addr[AW-1:0] > TOP) ? '0 : load_addr[AW-1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= start_addr;
        end else if (inc) begin
            addr_q <= (addr_q == TOP) ? '0 : addr_q + AW'(1);
        end
    end

    assign addr = addr_q;

    assert_wrap_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && addr_q == TOP) |=> (addr_q == '0));

    assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && addr_q != TOP) |=> (addr_q == $past(addr_q) + AW'(1)));

    assert_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q <= TOP);

endmodule

// File: rtl/sre_tx_shift.sv
module sre_tx_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       shift,
    output logic       so_d,
    output logic       so_oe,
    output logic       byte_done
);
    logic [7:0] shreg_q;
    logic [3:0] cnt_q;
    logic       so_q;
    logic       oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            so_q    <= 1'b0;
            oe_q    <= 1'b0;
        end else if (clear) begin
            cnt_q   <= '0;
            oe_q    <= 1'b0;
            so_q    <= 1'b0;
        end else if (load) begin
            shreg_q <= load_byte;
            cnt_q   <= '0;
        end else if (shift) begin
            so_q    <= shreg_q[7];
            shreg_q <= {shreg_q[6:0], 1'b0};
            cnt_q   <= cnt_q + 4'd1;
            oe_q    <= 1'b1;
        end
    end

    assign so_d      = so_q;
    assign so_oe     = oe_q;
    assign byte_done = (cnt_q == 4'd8);

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= 4'd8);

    assert_clear_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !so_oe);

endmodule

// File: rtl/spi_read_engine.sv
module spi_read_engine #(
    parameter int  MEM_DEPTH   = 1024,
    parameter int  SYNC_STAGES = 2,
    localparam int AW          = $clog2(MEM_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          si,
    input  logic          busy,
    output logic          so_d,
    output logic          so_oe,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata
);
    import spi_rd_pkg::*;

    localparam int CW = $clog2(ADDR_BITS);

    rd_state_e         state_q, state_d;
    logic [CW-1:0]     bit_cnt_q;
    logic [22:0]       sh_in_q;
    logic              fast_q;

    logic              cs_s, si_s, rise, fall;
    logic              byte_done;
    logic              addr_load, addr_inc;
    logic              tx_load, tx_shift;
    logic [7:0]        opcode_w;
    logic [23:0]       addr_w;
    logic              opc_last, addr_last, dummy_last;
    logic              opc_ok;

    sre_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (cs_n),
        .sck_i    (sck),
        .si_i     (si),
        .cs_n_s   (cs_s),
        .si_s     (si_s),
        .sck_rise (rise),
        .sck_fall (fall)
    );

    sre_addr_ctr #(.DEPTH(MEM_DEPTH), .AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_load),
        .load_addr (addr_w),
        .inc       (addr_inc),
        .addr      (mem_addr)
    );

    sre_tx_shift u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cs_s),
        .load      (tx_load),
        .load_byte (mem_rdata),
        .shift     (tx_shift),
        .so_d      (so_d),
        .so_oe     (so_oe),
        .byte_done (byte_done)
    );

    assign opcode_w   = {sh_in_q[6:0], si_s};
    assign addr_w     = {sh_in_q, si_s};
    assign opc_last   = rise && (bit_cnt_q == CW'(OPC_BITS - 1));
    assign addr_last  = rise && (bit_cnt_q == CW'(ADDR_BITS - 1));
    assign dummy_last = rise && (bit_cnt_q == CW'(DUMMY_BITS - 1));
    assign opc_ok     = ((opcode_w == OPC_READ) || (opcode_w == OPC_FAST_READ)) && !busy;

    // State register and bit-level datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            sh_in_q   <= '0;
            fast_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                bit_cnt_q <= '0;
            end else if (rise) begin
                bit_cnt_q <= bit_cnt_q + CW'(1);
            end
            if (rise) begin
                sh_in_q <= {sh_in_q[21:0], si_s};
            end
            if (state_q == ST_OPCODE && opc_last) begin
                fast_q <= (opcode_w == OPC_FAST_READ);
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: if (opc_last) state_d = opc_ok ? ST_ADDR : ST_REJECT;
                ST_ADDR:   if (addr_last) state_d = fast_q ? ST_DUMMY : ST_FETCH;
                ST_DUMMY:  if (dummy_last) state_d = ST_FETCH;
                ST_FETCH:  state_d = ST_LOAD;
                ST_LOAD:   state_d = ST_STREAM;
                ST_STREAM: if (byte_done) state_d = ST_FETCH;
                ST_REJECT: state_d = ST_REJECT;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        mem_rd_en = 1'b0;
        addr_load = 1'b0;
        addr_inc  = 1'b0;
        tx_load   = 1'b0;
        tx_shift  = 1'b0;
        if (!cs_s) begin
            unique case (state_q)
                ST_ADDR:   addr_load = addr_last;
                ST_FETCH:  mem_rd_en = 1'b1;
                ST_LOAD:   tx_load   = 1'b1;
                ST_STREAM: begin
                    tx_shift = fall && !byte_done;
                    addr_inc = byte_done;
                end
                default: ;
            endcase
        end
    end

    assert_hdr_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPCODE || state_q == ST_ADDR || state_q == ST_DUMMY) |-> !so_oe);

    assert_reject_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REJECT) |-> (!mem_rd_en && !so_oe));

    assert_cs_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (state_q == ST_IDLE && !so_oe));

    assert_single_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    assert_busy_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPCODE && opc_last && busy && !cs_s) |=> (state_q == ST_REJECT));

endmodule

// File: tb/sim_spi_read_engine.sv
`timescale 1ns/1ps
module sim_spi_read_engine;

    localparam int DEPTH = 1024;
    localparam int AW    = $clog2(DEPTH);
    localparam int HALF  = 6;
    localparam int LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          si = 1'b0;
    logic          busy = 1'b0;
    logic          so_d, so_oe, mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata = 8'h00;

    int n_chk = 0;
    int n_fail = 0;
    int rd_pulses = 0;
    int idle_cnt = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    spi_read_engine #(.MEM_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .busy(busy),
        .so_d(so_d), .so_oe(so_oe), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] memf(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    // Memory model: data one cycle after the strobe
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= memf(int'(mem_addr));
        if (mem_rd_en) rd_pulses <= rd_pulses + 1;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison while deselected: R1
    always @(negedge clk) begin
        cyc++;
        if (cs_n && rst_n) idle_cnt++; else idle_cnt = 0;
        if (idle_cnt == 5) check(!so_oe && !mem_rd_en, "R1 idle quiet", {so_oe, mem_rd_en}, 0);
        if (cyc > LIMIT) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic bit_cycle(input logic b, output logic d, output logic oe);
        si = b;
        repeat (HALF) @(negedge clk);
        d  = so_d;
        oe = so_oe;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic deselect();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        si   = 1'b0;
        busy = 1'b0;
        repeat (4) @(negedge clk);
        check(!so_oe, "R11 off after deselect", so_oe, 0);
        repeat (6) @(negedge clk);
    endtask

    task automatic txn(input logic [7:0] op, input logic [23:0] a, input int nbytes,
                       input int xbits, input logic bsy_op, input logic bsy_after,
                       input string tag);
        logic d, oe;
        logic acc, fast;
        int   e;
        logic [7:0] eb;
        acc  = ((op == 8'h03) || (op == 8'h0B)) && !bsy_op;
        fast = (op == 8'h0B);
        busy = bsy_op;
        rd_pulses = 0;
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(op[i], d, oe);
            check(!oe, {"R8 opcode hiz ", tag}, oe, 0);
        end
        busy = bsy_after;
        for (int i = 23; i >= 0; i--) begin
            bit_cycle(a[i], d, oe);
            check(!oe, {"R8 address hiz ", tag}, oe, 0);
        end
        if (acc && fast) begin
            for (int i = 0; i < 8; i++) begin
                bit_cycle(1'b1, d, oe);
                check(!oe, {"R3 dummy hiz ", tag}, oe, 0);
            end
        end
        e = int'(a) % DEPTH;
        for (int k = 0; k <= nbytes; k++) begin
            eb = memf(e);
            for (int i = 7; i >= 0; i--) begin
                if (k == nbytes && (7 - i) >= xbits) break;
                bit_cycle(1'b0, d, oe);
                if (acc) check(oe && (d == eb[i]), {"R4 data bit ", tag}, {oe, d}, {1'b1, eb[i]});
                else     check(!oe, {"R9 R10 refused hiz ", tag}, oe, 0);
            end
            e = (e + 1) % DEPTH;
        end
        repeat (HALF) @(negedge clk);
        check(rd_pulses == (acc ? nbytes + 1 : 0), {"R12 read count ", tag},
              rd_pulses, acc ? nbytes + 1 : 0);
        deselect();
    endtask

    initial begin
        logic d, oe;
        repeat (4) @(negedge clk);
        check(!so_oe && !mem_rd_en, "R1 reset state", {so_oe, mem_rd_en}, 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        check(!so_oe && !mem_rd_en, "R1 after reset", {so_oe, mem_rd_en}, 0);

        txn(8'h03, 24'h000010, 4, 0, 1'b0, 1'b0, "R2 R5 plain read");
        txn(8'h0B, 24'h0003FD, 5, 0, 1'b0, 1'b0, "R3 R6 fast read wrap");
        txn(8'h03, 24'hABC3FF, 2, 3, 1'b0, 1'b0, "R7 R6 R11 upper bits, stop mid byte");
        txn(8'h9F, 24'h000020, 3, 0, 1'b0, 1'b0, "R9 unknown opcode");
        txn(8'h03, 24'h000040, 2, 0, 1'b1, 1'b0, "R10 busy then clear");
        txn(8'h0B, 24'h000040, 2, 0, 1'b1, 1'b1, "R10 busy held");
        txn(8'h03, 24'h000200, 1, 0, 1'b0, 1'b0, "R10 R11 recovery");

        // Deselect inside the address, then a fresh command: R11
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 7; i >= 0; i--) bit_cycle(((8'h0B >> i) & 8'h01) != 0, d, oe);
        for (int i = 0; i < 10; i++) begin
            bit_cycle(1'b1, d, oe);
            check(!oe, "R11 partial address hiz", oe, 0);
        end
        deselect();
        txn(8'h03, 24'h000123, 2, 0, 1'b0, 1'b0, "R11 fresh after abort");
        txn(8'h0B, 24'h000000, 1, 5, 1'b0, 1'b0, "R3 R5 fast from zero");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule